// File: doc/BRIEF.md
# Display Controller Serial Command Receiver

This block is the host-facing front end of a dot-matrix display controller. A host writes to it over a three-wire, write-only serial port made of an active-low select, a shift clock and a data line. The block brings those pins into the system clock domain and collects bits into bytes. It treats the first complete byte of each select-low frame as a command. Every byte that follows is data for whatever that command chose.

Three commands open a RAM write burst: character codes, user-defined 5x7 glyphs, and two-bit per-digit symbols. For these, the command byte also carries the start address. Each data byte produces a one-cycle write strobe with address and data, and the address then steps up by one and wraps at the top of its RAM. A glyph is sent as five column bytes and leaves the block as one 35-bit word. The remaining commands load the control registers held here: port outputs, duty code, digit-count code, the display mode bits, and a test-mode flag.

Top module: `vfd_cmd_rx`

## Requirements
- R1: Bits are taken only while `ser_cs_n` is low. Raising `ser_cs_n` discards any partial byte and ends the frame, so the first complete byte of the next frame is decoded as a command.
- R2: Each byte is 8 bits long, sampled on rising edges of `ser_clk` and shifted in least significant bit first. A byte sent as 0x41 is seen as 0x41.
- R3: Bits 7..5 of the command byte select the operation: 000 character RAM, 001 glyph RAM, 010 symbol RAM, 011 port, 100 duty, 101 digit count, 110 mode, 111 test. Bytes that follow a non-RAM command in the same frame have no effect, and at most one write strobe is active in any cycle.
- R4: After a 000 command with start address in bits 3..0, each data byte raises `char_we` for one cycle with `char_addr` and `char_data`. The address then advances by one and wraps from 15 to 0.
- R5: After a 001 command with start address in bits 2..0, five data bytes form one glyph: bit j (0..6) of column byte k (0..4) becomes bit 5j+k of `ucg_data`, and bit 7 is ignored. `ucg_we` pulses only on the fifth byte. The address then wraps from 7 to 0. The column count restarts whenever `ser_cs_n` falls.
- R6: After a 010 command with start address in bits 3..0, each data byte raises `sym_we` with `sym_data` equal to bits 1..0 of the byte. The address wraps from 15 to 0.
- R7: Command 011 loads `port_out` from bits 1..0. Command 100 loads `duty_code` from bits 2..0. Command 101 loads `digit_code` from bits 2..0.
- R8: Command 110 loads `mode_bits` from bits 3..0, ordered {display on, standby, all lit, all dark}.
- R9: Reset sets `port_out` to 11, `duty_code`, `digit_code` and `mode_bits` to 0, `test_mode` to 0, and all write addresses to 0.
- R10: Byte 0xE0 sets `test_mode` only while `test_en` is high. Any other 111 byte, or 0xE0 with `test_en` low, is ignored.
- R11: A falling edge of `ser_cs_n` while the standby bit is set clears both the standby bit and the display-on bit. When standby is clear, the falling edge leaves `mode_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Enables acceptance of the test command |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, LSB first |
| char_we | output | 1 | Character RAM write strobe |
| char_addr | output | 4 | Character RAM write address |
| char_data | output | 8 | Character code to write |
| ucg_we | output | 1 | Glyph RAM write strobe |
| ucg_addr | output | 3 | Glyph RAM write address |
| ucg_data | output | 35 | Assembled 5x7 glyph word |
| sym_we | output | 1 | Symbol RAM write strobe |
| sym_addr | output | 4 | Symbol RAM write address |
| sym_data | output | 2 | Symbol bits to write |
| port_out | output | 2 | General port levels |
| duty_code | output | 3 | Duty selection code |
| digit_code | output | 3 | Digit count code |
| mode_bits | output | 4 | {display on, standby, all lit, all dark} |
| test_mode | output | 1 | Test mode accepted |

## Verification
The assertions assume the serial pins move far more slowly than the system clock. Each level of `ser_clk` must last at least three system cycles, so the synchronizer never drops or merges an edge. `ser_cs_n` is assumed to change only while `ser_clk` is low and settled, and `test_en` is assumed quasi-static. The stimulus holds every serial level for four cycles, and it moves select and data only away from the serial rising edge. A falling select therefore never lands in the same cycle as a completed byte, which the wake-up property relies on.

// File: rtl/vfdrx_pkg.sv
package vfdrx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CHAR = 2'd1,
        TGT_UCG  = 2'd2,
        TGT_SYM  = 2'd3
    } tgt_e;

    localparam logic [2:0] OP_CHAR  = 3'b000;
    localparam logic [2:0] OP_UCG   = 3'b001;
    localparam logic [2:0] OP_SYM   = 3'b010;
    localparam logic [2:0] OP_PORT  = 3'b011;
    localparam logic [2:0] OP_DUTY  = 3'b100;
    localparam logic [2:0] OP_DIGIT = 3'b101;
    localparam logic [2:0] OP_MODE  = 3'b110;
    localparam logic [2:0] OP_TEST  = 3'b111;

    localparam int MODE_D = 3;
    localparam int MODE_S = 2;
endpackage

// File: rtl/vfdrx_sync.sv
module vfdrx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/vfdrx_shifter.sv
module vfdrx_shifter
    import vfdrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              dat_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out,
    output logic              cs_fall
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              sck_prev;
        logic              cs_prev;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
    } sh_t;

    sh_t sh_q, sh_d;
    logic sck_rise;

    assign sck_rise = sck_s && !sh_q.sck_prev;

    always_comb begin
        sh_d          = sh_q;
        sh_d.sck_prev = sck_s;
        sh_d.cs_prev  = cs_n_s;
        sh_d.vld      = 1'b0;
        if (cs_n_s) begin
            sh_d.cnt = '0;
        end else if (sck_rise) begin
            sh_d.shreg = {dat_s, sh_q.shreg[BYTE_W-1:1]};
            if (sh_q.cnt == CNT_W'(BYTE_W-1)) begin
                sh_d.cnt = '0;
                sh_d.vld = 1'b1;
            end else begin
                sh_d.cnt = sh_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q          <= '0;
            sh_q.cs_prev  <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign byte_vld = sh_q.vld;
    assign byte_out = sh_q.shreg;
    assign cs_fall  = sh_q.cs_prev && !cs_n_s;

    // R1: a raised select clears any partial bit count
    p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (sh_q.cnt == '0));

    // R2: a completed byte needs a serial rising edge in the cycle before
    p_byte_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.vld |-> $past(sck_rise));
endmodule

// File: rtl/vfdrx_seq.sv
module vfdrx_seq
    import vfdrx_pkg::*;
#(
    parameter int CHAR_AW = 4,
    parameter int UCG_AW  = 3,
    parameter int COLS    = 5,
    parameter int ROWS    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              cs_fall,
    output logic              char_we,
    output logic [CHAR_AW-1:0] char_addr,
    output logic [BYTE_W-1:0] char_data,
    output logic              ucg_we,
    output logic [UCG_AW-1:0] ucg_addr,
    output logic [COLS*ROWS-1:0] ucg_data,
    output logic              sym_we,
    output logic [CHAR_AW-1:0] sym_addr,
    output logic [1:0]        sym_data,
    output logic [1:0]        port_out,
    output logic [2:0]        duty_code,
    output logic [2:0]        digit_code,
    output logic [3:0]        mode_bits,
    output logic              test_mode
);
    localparam int AW = (CHAR_AW > UCG_AW) ? CHAR_AW : UCG_AW;
    localparam int CW = $clog2(COLS);
    localparam int PW = COLS * ROWS;
    localparam logic [AW-1:0] CHAR_LAST = AW'((1 << CHAR_AW) - 1);
    localparam logic [AW-1:0] UCG_LAST  = AW'((1 << UCG_AW) - 1);

    typedef struct packed {
        logic              first;
        tgt_e              tgt;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     waddr;
        logic [CW-1:0]     col;
        logic [PW-1:0]     pat;
        logic [BYTE_W-1:0] wdata;
        logic              char_we;
        logic              ucg_we;
        logic              sym_we;
        logic [1:0]        port;
        logic [2:0]        duty;
        logic [2:0]        digits;
        logic [3:0]        mode;
        logic              test;
    } sq_t;

    sq_t q, n;
    logic [2:0] opcode;

    assign opcode = byte_in[BYTE_W-1:BYTE_W-3];

    always_comb begin
        n         = q;
        n.char_we = 1'b0;
        n.ucg_we  = 1'b0;
        n.sym_we  = 1'b0;

        if (cs_fall) begin
            n.first = 1'b1;
            n.col   = '0;
            if (q.mode[MODE_S]) begin
                n.mode[MODE_S] = 1'b0;
                n.mode[MODE_D] = 1'b0;
            end
        end

        if (byte_vld) begin
            if (q.first) begin
                n.first = 1'b0;
                n.tgt   = TGT_NONE;
                unique case (opcode)
                    OP_CHAR: begin
                        n.tgt  = TGT_CHAR;
                        n.addr = AW'(byte_in[CHAR_AW-1:0]);
                    end
                    OP_UCG: begin
                        n.tgt  = TGT_UCG;
                        n.addr = AW'(byte_in[UCG_AW-1:0]);
                        n.col  = '0;
                    end
                    OP_SYM: begin
                        n.tgt  = TGT_SYM;
                        n.addr = AW'(byte_in[CHAR_AW-1:0]);
                    end
                    OP_PORT:  n.port   = byte_in[1:0];
                    OP_DUTY:  n.duty   = byte_in[2:0];
                    OP_DIGIT: n.digits = byte_in[2:0];
                    OP_MODE:  n.mode   = byte_in[3:0];
                    OP_TEST: begin
                        if (byte_in[4:0] == 5'd0 && test_en) n.test = 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                unique case (q.tgt)
                    TGT_CHAR: begin
                        n.char_we = 1'b1;
                        n.waddr   = q.addr;
                        n.wdata   = byte_in;
                        n.addr    = (q.addr == CHAR_LAST) ? '0 : q.addr + 1'b1;
                    end
                    TGT_SYM: begin
                        n.sym_we = 1'b1;
                        n.waddr  = q.addr;
                        n.wdata  = byte_in;
                        n.addr   = (q.addr == CHAR_LAST) ? '0 : q.addr + 1'b1;
                    end
                    TGT_UCG: begin
                        for (int k = 0; k < COLS; k++) begin
                            if (q.col == CW'(k)) begin
                                for (int j = 0; j < ROWS; j++) begin
                                    n.pat[j*COLS+k] = byte_in[j];
                                end
                            end
                        end
                        if (q.col == CW'(COLS-1)) begin
                            n.ucg_we = 1'b1;
                            n.waddr  = q.addr;
                            n.col    = '0;
                            n.addr   = (q.addr == UCG_LAST) ? '0 : q.addr + 1'b1;
                        end else begin
                            n.col = q.col + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.first <= 1'b1;
            q.tgt   <= TGT_NONE;
            q.port  <= 2'b11;
        end else begin
            q <= n;
        end
    end

    assign char_we    = q.char_we;
    assign char_addr  = q.waddr[CHAR_AW-1:0];
    assign char_data  = q.wdata;
    assign ucg_we     = q.ucg_we;
    assign ucg_addr   = q.waddr[UCG_AW-1:0];
    assign ucg_data   = q.pat;
    assign sym_we     = q.sym_we;
    assign sym_addr   = q.waddr[CHAR_AW-1:0];
    assign sym_data   = q.wdata[1:0];
    assign port_out   = q.port;
    assign duty_code  = q.duty;
    assign digit_code = q.digits;
    assign mode_bits  = q.mode;
    assign test_mode  = q.test;

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.char_we, q.ucg_we, q.sym_we}));

    p_ucg_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ucg_we |-> (q.col == '0));

    p_strobe_needs_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.char_we || q.sym_we || q.ucg_we) |-> $past(byte_vld));

    p_port_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(q.port));

    p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && q.mode[MODE_S]) |=> (!q.mode[MODE_S] && !q.mode[MODE_D]));

    p_test_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.test) |-> $past(test_en));
endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx
    import vfdrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CHAR_AW     = 4,
    parameter int UCG_AW      = 3,
    parameter int COLS        = 5,
    parameter int ROWS        = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_en,
    input  logic                 ser_cs_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    output logic                 char_we,
    output logic [CHAR_AW-1:0]   char_addr,
    output logic [BYTE_W-1:0]    char_data,
    output logic                 ucg_we,
    output logic [UCG_AW-1:0]    ucg_addr,
    output logic [COLS*ROWS-1:0] ucg_data,
    output logic                 sym_we,
    output logic [CHAR_AW-1:0]   sym_addr,
    output logic [1:0]           sym_data,
    output logic [1:0]           port_out,
    output logic [2:0]           duty_code,
    output logic [2:0]           digit_code,
    output logic [3:0]           mode_bits,
    output logic                 test_mode
);
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] PIN_RST = 4'b0100;

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_s;
    logic            byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic            cs_fall;

    assign pin_raw = {test_en, ser_cs_n, ser_clk, ser_dat};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        vfdrx_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (PIN_RST[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[g]),
            .q     (pin_s[g])
        );
    end

    vfdrx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pin_s[2]),
        .sck_s    (pin_s[1]),
        .dat_s    (pin_s[0]),
        .byte_vld (byte_vld),
        .byte_out (byte_val),
        .cs_fall  (cs_fall)
    );

    vfdrx_seq #(
        .CHAR_AW (CHAR_AW),
        .UCG_AW  (UCG_AW),
        .COLS    (COLS),
        .ROWS    (ROWS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (pin_s[3]),
        .byte_vld   (byte_vld),
        .byte_in    (byte_val),
        .cs_fall    (cs_fall),
        .char_we    (char_we),
        .char_addr  (char_addr),
        .char_data  (char_data),
        .ucg_we     (ucg_we),
        .ucg_addr   (ucg_addr),
        .ucg_data   (ucg_data),
        .sym_we     (sym_we),
        .sym_addr   (sym_addr),
        .sym_data   (sym_data),
        .port_out   (port_out),
        .duty_code  (duty_code),
        .digit_code (digit_code),
        .mode_bits  (mode_bits),
        .test_mode  (test_mode)
    );
endmodule

// File: tb/vfd_cmd_rx_test.sv
module vfd_cmd_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0;
    logic ser_cs_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic        char_we, ucg_we, sym_we, test_mode;
    logic [3:0]  char_addr, sym_addr, mode_bits;
    logic [7:0]  char_data;
    logic [2:0]  ucg_addr, duty_code, digit_code;
    logic [34:0] ucg_data;
    logic [1:0]  sym_data, port_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0]  lg_kind [64];
    logic [3:0]  lg_addr [64];
    logic [34:0] lg_data [64];
    int n_log = 0;

    always #4 clk = ~clk;

    vfd_cmd_rx uut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en),
        .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .char_we(char_we), .char_addr(char_addr), .char_data(char_data),
        .ucg_we(ucg_we), .ucg_addr(ucg_addr), .ucg_data(ucg_data),
        .sym_we(sym_we), .sym_addr(sym_addr), .sym_data(sym_data),
        .port_out(port_out), .duty_code(duty_code), .digit_code(digit_code),
        .mode_bits(mode_bits), .test_mode(test_mode)
    );

    // write logger: kind 1 char, 2 glyph, 3 symbol
    always @(negedge clk) begin
        if (n_log < 64) begin
            if (char_we) begin
                lg_kind[n_log] = 2'd1; lg_addr[n_log] = char_addr;
                lg_data[n_log] = {27'd0, char_data}; n_log = n_log + 1;
            end else if (ucg_we) begin
                lg_kind[n_log] = 2'd2; lg_addr[n_log] = {1'b0, ucg_addr};
                lg_data[n_log] = ucg_data; n_log = n_log + 1;
            end else if (sym_we) begin
                lg_kind[n_log] = 2'd3; lg_addr[n_log] = sym_addr;
                lg_data[n_log] = {33'd0, sym_data}; n_log = n_log + 1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_log(input string req, input int idx, input logic [1:0] kind,
                             input logic [3:0] addr, input logic [34:0] data);
        if (idx >= n_log) check(req, "missing write", 64'(n_log), 64'(idx + 1));
        else begin
            check(req, "write kind", 64'(lg_kind[idx]), 64'(kind));
            check(req, "write addr", 64'(lg_addr[idx]), 64'(addr));
            check(req, "write data", 64'(lg_data[idx]), 64'(data));
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk); ser_cs_n = 1'b0; wait_clks(4);
    endtask

    task automatic cs_hi();
        wait_clks(4); ser_cs_n = 1'b1; wait_clks(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            ser_dat = b[i]; wait_clks(4);
            ser_clk = 1'b1; wait_clks(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    function automatic logic [34:0] glyph(input logic [7:0] c0, input logic [7:0] c1,
                                          input logic [7:0] c2, input logic [7:0] c3,
                                          input logic [7:0] c4);
        logic [7:0] c [5];
        logic [34:0] p;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3; c[4] = c4;
        p = '0;
        for (int k = 0; k < 5; k++)
            for (int j = 0; j < 7; j++)
                p[5*j+k] = c[k][j];
        return p;
    endfunction

    // {test_en, byte, port, duty, digits, mode, test}
    localparam int NV = 13;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 8'h61, 2'b01, 3'd0, 3'd0, 4'b0000, 1'b0},
        {1'b0, 8'h82, 2'b01, 3'd2, 3'd0, 4'b0000, 1'b0},
        {1'b0, 8'hA7, 2'b01, 3'd2, 3'd7, 4'b0000, 1'b0},
        {1'b0, 8'hC9, 2'b01, 3'd2, 3'd7, 4'b1001, 1'b0},
        {1'b0, 8'hE0, 2'b01, 3'd2, 3'd7, 4'b1001, 1'b0},
        {1'b0, 8'h7E, 2'b10, 3'd2, 3'd7, 4'b1001, 1'b0},
        {1'b0, 8'h9D, 2'b10, 3'd5, 3'd7, 4'b1001, 1'b0},
        {1'b0, 8'hB8, 2'b10, 3'd5, 3'd0, 4'b1001, 1'b0},
        {1'b0, 8'hC6, 2'b10, 3'd5, 3'd0, 4'b0110, 1'b0},
        {1'b0, 8'h83, 2'b10, 3'd3, 3'd0, 4'b0010, 1'b0},
        {1'b0, 8'hC8, 2'b10, 3'd3, 3'd0, 4'b1000, 1'b0},
        {1'b1, 8'hFF, 2'b10, 3'd3, 3'd0, 4'b1000, 1'b0},
        {1'b1, 8'hE0, 2'b10, 3'd3, 3'd0, 4'b1000, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);
        // R9 reset state
        check("R9", "port", 64'(port_out), 64'd3);
        check("R9", "duty", 64'(duty_code), 64'd0);
        check("R9", "digits", 64'(digit_code), 64'd0);
        check("R9", "mode", 64'(mode_bits), 64'd0);
        check("R9", "test", 64'(test_mode), 64'd0);

        // R7 R8 R10 R11 register command table
        for (int v = 0; v < NV; v++) begin
            test_en = VEC[v][21];
            wait_clks(4);
            cs_lo(); send_byte(VEC[v][20:13]); cs_hi();
            check("R7", "port", 64'(port_out), 64'(VEC[v][12:11]));
            check("R7", "duty", 64'(duty_code), 64'(VEC[v][10:8]));
            check("R7", "digits", 64'(digit_code), 64'(VEC[v][7:5]));
            check("R8_R11", "mode", 64'(mode_bits), 64'(VEC[v][4:1]));
            check("R10", "test", 64'(test_mode), 64'(VEC[v][0]));
        end
        test_en = 1'b0;

        // R4 R2: character writes with wrap 15 -> 0, LSB-first bytes
        base = n_log;
        cs_lo(); send_byte(8'h0E); send_byte(8'h41); send_byte(8'h42); send_byte(8'h43); cs_hi();
        check_log("R2_R4", base,     2'd1, 4'hE, 35'h41);
        check_log("R4",    base + 1, 2'd1, 4'hF, 35'h42);
        check_log("R4",    base + 2, 2'd1, 4'h0, 35'h43);

        // R3: bytes after a register command do nothing
        base = n_log;
        cs_lo(); send_byte(8'h61); send_byte(8'h00); send_byte(8'h7E); cs_hi();
        check("R3", "writes after port cmd", 64'(n_log - base), 64'd0);
        check("R3", "port after trailing bytes", 64'(port_out), 64'd1);

        // R1: a partial byte is dropped when select rises
        base = n_log;
        cs_lo(); send_bits(8'h03, 5); cs_hi();
        check("R1", "no write on partial", 64'(n_log - base), 64'd0);
        cs_lo(); send_byte(8'h05); send_byte(8'h55); cs_hi();
        check_log("R1", base, 2'd1, 4'h5, 35'h55);

        // R6: symbol writes, upper bits dropped, wrap 15 -> 0
        base = n_log;
        cs_lo(); send_byte(8'h4F); send_byte(8'hFE); send_byte(8'h01); cs_hi();
        check_log("R6", base,     2'd3, 4'hF, 35'h2);
        check_log("R6", base + 1, 2'd3, 4'h0, 35'h1);

        // R5: glyph assembly, commit on fifth byte, wrap 7 -> 0
        base = n_log;
        cs_lo(); send_byte(8'h27);
        send_byte(8'h85); send_byte(8'h2A); send_byte(8'h7F); send_byte(8'h00);
        wait_clks(6);
        check("R5", "no glyph before fifth byte", 64'(n_log - base), 64'd0);
        send_byte(8'hD3);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h04); send_byte(8'h08); send_byte(8'h10);
        cs_hi();
        check_log("R5", base,     2'd2, 4'h7, glyph(8'h85, 8'h2A, 8'h7F, 8'h00, 8'hD3));
        check_log("R5", base + 1, 2'd2, 4'h0, glyph(8'h01, 8'h02, 8'h04, 8'h08, 8'h10));

        // R5: column count restarts on a new frame
        base = n_log;
        cs_lo(); send_byte(8'h22); send_byte(8'h7F); send_byte(8'h7F); send_byte(8'h7F); cs_hi();
        cs_lo(); send_byte(8'h23);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h04); send_byte(8'h08); send_byte(8'h10);
        cs_hi();
        check("R5", "one glyph after restart", 64'(n_log - base), 64'd1);
        check_log("R5", base, 2'd2, 4'h3, glyph(8'h01, 8'h02, 8'h04, 8'h08, 8'h10));

        // R11: select fall without standby leaves mode alone
        cs_lo(); send_byte(8'hCB); cs_hi();
        cs_lo(); send_byte(8'h60); cs_hi();
        check("R11", "mode kept without standby", 64'(mode_bits), 64'hB);

        // R9: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0; wait_clks(3); rst_n = 1'b1; wait_clks(3);
        check("R9", "port after reset", 64'(port_out), 64'd3);
        check("R9", "mode after reset", 64'(mode_bits), 64'd0);
        check("R9", "test after reset", 64'(test_mode), 64'd0);
        check("R9", "duty after reset", 64'(duty_code), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule